// File: doc/BRIEF.md
# Shared Memory-Port I/O Fabric

This block lets one processor memory port serve on-chip RAM and up to seven I/O modules without a central arbiter. The top bits of the 32-bit address name a region. Every region has its own slot inside the fabric. A slot decodes the region for itself and raises its own select, write strobe and read strobe only when the address falls in its region. The remaining address bits and the write data go to all devices unchanged.

No tri-state lines are used. A slot that is not selected drives zeros, and the read data seen by the processor is the bitwise OR of all slot outputs. Read data comes back one clock after the read strobe for every target. The memory slot relies on the synchronous RAM's own output register. Each I/O slot captures its device's combinational data in a register so that it has the same latency.

An access to a region that no slot claims selects nothing and returns zero. It also produces a one-cycle error pulse, aligned with the cycle in which the read data would have appeared.

Top module: `mmio_fabric`

## Requirements
- R1: During a read or write access, the region field `cpu_addr[31:28]` with value i (0 to 7) asserts `dev_sel[i]` and no other select bit. With neither strobe high, no select bit is asserted.
- R2: `dev_wr[i]` is high only when region i is addressed and `cpu_wr` is high. A write to one region leaves the state of every other device unchanged.
- R3: `dev_rd[i]` is high only when region i is addressed and `cpu_rd` is high.
- R4: After a read of region 0 in cycle k, `cpu_rdata` in cycle k+1 equals the data the RAM presents on `dev_rdata[31:0]` in cycle k+1.
- R5: After a read of region i (1 to 7) in cycle k, `cpu_rdata` in cycle k+1 equals `dev_rdata[i*32 +: 32]` as it was in cycle k.
- R6: `cpu_rdata` is zero in every cycle that does not follow a read of a claimed region, including cycles that follow writes.
- R7: An access (read or write) to regions 8 to 15 asserts no select or strobe. It returns zero read data, and `bus_err` is high for exactly the following cycle.
- R8: While `rst_n` is low, `cpu_rdata` and `bus_err` are zero.
- R9: `dev_addr` equals `cpu_addr[27:0]` and `dev_wdata` equals `cpu_wdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 32 | Processor address; bits 31:28 name the region |
| cpu_wdata | input | 32 | Processor write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 32 | Merged read data, valid one cycle after the read |
| bus_err | output | 1 | One-cycle pulse after an access to an unclaimed region |
| dev_sel | output | 8 | Per-region select |
| dev_wr | output | 8 | Per-region gated write strobe |
| dev_rd | output | 8 | Per-region gated read strobe |
| dev_addr | output | 28 | Offset within the region, shared by all devices |
| dev_wdata | output | 32 | Write data, shared by all devices |
| dev_rdata | input | 256 | Device return data, 32 bits per region, region i at bits i*32+31:i*32 |

## Verification
A slot whose decode or strobe gating is wrong writes into the wrong device. This shows up one cycle later, when that device or its neighbour is read back and returns the wrong word. A capture register that holds stale data, or is not cleared, ORs a leftover word onto the next unrelated read, or onto the cycle after a write, at the very next clock. A wrong error flag shows at the cycle after the unmapped access: either the pulse is missing, or it lasts a second cycle.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

   // How a slot produces its one-cycle read latency
   typedef enum logic {
      SLOT_SYNC_MEM = 1'b0,   // device output is already registered; slot gates it
      SLOT_REG_IO   = 1'b1    // device output is combinational; slot registers it
   } slot_kind_e;

   function automatic slot_kind_e kind_for_slot(input int unsigned idx,
                                                input int unsigned mem_slots);
      return (idx < mem_slots) ? SLOT_SYNC_MEM : SLOT_REG_IO;
   endfunction

endpackage

// File: rtl/mmio_slot.sv
module mmio_slot
   import mmio_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REGION_W = 4,
   parameter int unsigned SLOT_ID  = 0,
   parameter slot_kind_e  KIND     = SLOT_REG_IO
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REGION_W-1:0] region,
   input  logic                cpu_rd,
   input  logic                cpu_wr,
   input  logic [DATA_W-1:0]   dev_rdata,
   output logic                sel,
   output logic                wr_stb,
   output logic                rd_stb,
   output logic [DATA_W-1:0]   slot_rdata
);

   localparam logic [REGION_W-1:0] MY_REGION = REGION_W'(SLOT_ID);

   logic hit;
   assign hit    = (region == MY_REGION);
   assign sel    = hit & (cpu_rd | cpu_wr);
   assign wr_stb = hit & cpu_wr;
   assign rd_stb = hit & cpu_rd;

   generate
      if (KIND == SLOT_SYNC_MEM) begin : g_mem
         logic rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= 1'b0;
            else        rd_q <= rd_stb;
         end
         assign slot_rdata = rd_q ? dev_rdata : '0;
      end else begin : g_io
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) data_q <= '0;
            else        data_q <= rd_stb ? dev_rdata : '0;
         end
         assign slot_rdata = data_q;

         AST_IO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb |=> (slot_rdata == $past(dev_rdata))); // R5
      end
   endgenerate

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (slot_rdata == '0)); // R6

endmodule

// File: rtl/mmio_or_merge.sv
module mmio_or_merge #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = 8
)(
   input  logic [LANES*DATA_W-1:0] lanes,
   output logic [DATA_W-1:0]       merged
);

   always_comb begin
      merged = '0;
      for (int i = 0; i < LANES; i++) begin
         merged = merged | lanes[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/mmio_unmapped.sv
module mmio_unmapped #(
   parameter int unsigned REGION_W  = 4,
   parameter int unsigned NUM_SLOTS = 8
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REGION_W-1:0] region,
   input  logic                cpu_rd,
   input  logic                cpu_wr,
   output logic                bus_err
);

   localparam logic [REGION_W:0] FIRST_FREE = (REGION_W+1)'(NUM_SLOTS);

   logic miss;
   assign miss = ({1'b0, region} >= FIRST_FREE) & (cpu_rd | cpu_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_err <= 1'b0;
      else        bus_err <= miss;
   end

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past((cpu_rd | cpu_wr) && ({1'b0, region} >= FIRST_FREE))); // R7

endmodule

// File: rtl/mmio_fabric.sv
module mmio_fabric
   import mmio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned REGION_W  = 4,
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned MEM_SLOTS = 1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             cpu_addr,
   input  logic [DATA_W-1:0]             cpu_wdata,
   input  logic                          cpu_wr,
   input  logic                          cpu_rd,
   output logic [DATA_W-1:0]             cpu_rdata,
   output logic                          bus_err,
   output logic [NUM_SLOTS-1:0]          dev_sel,
   output logic [NUM_SLOTS-1:0]          dev_wr,
   output logic [NUM_SLOTS-1:0]          dev_rd,
   output logic [ADDR_W-REGION_W-1:0]    dev_addr,
   output logic [DATA_W-1:0]             dev_wdata,
   input  logic [NUM_SLOTS*DATA_W-1:0]   dev_rdata
);

   localparam int unsigned OFF_W = ADDR_W - REGION_W;

   generate
      if (REGION_W >= ADDR_W) begin : g_bad_region
         $error("region field must be narrower than the address");
      end
      if (NUM_SLOTS > (1 << REGION_W)) begin : g_bad_slots
         $error("more slots than regions");
      end
      if (MEM_SLOTS > NUM_SLOTS) begin : g_bad_mem
         $error("memory slot count exceeds slot count");
      end
   endgenerate

   logic [REGION_W-1:0]          region;
   logic [NUM_SLOTS*DATA_W-1:0]  slot_lanes;

   assign region    = cpu_addr[ADDR_W-1 -: REGION_W];
   assign dev_addr  = cpu_addr[OFF_W-1:0];
   assign dev_wdata = cpu_wdata;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         mmio_slot #(
            .DATA_W   (DATA_W),
            .REGION_W (REGION_W),
            .SLOT_ID  (s),
            .KIND     (kind_for_slot(s, MEM_SLOTS))
         ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .region     (region),
            .cpu_rd     (cpu_rd),
            .cpu_wr     (cpu_wr),
            .dev_rdata  (dev_rdata[s*DATA_W +: DATA_W]),
            .sel        (dev_sel[s]),
            .wr_stb     (dev_wr[s]),
            .rd_stb     (dev_rd[s]),
            .slot_rdata (slot_lanes[s*DATA_W +: DATA_W])
         );
      end
   endgenerate

   mmio_or_merge #(
      .DATA_W (DATA_W),
      .LANES  (NUM_SLOTS)
   ) merge_i (
      .lanes  (slot_lanes),
      .merged (cpu_rdata)
   );

   mmio_unmapped #(
      .REGION_W  (REGION_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) unmapped_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .region  (region),
      .cpu_rd  (cpu_rd),
      .cpu_wr  (cpu_wr),
      .bus_err (bus_err)
   );

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel)); // R1

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_wr) && ((dev_wr == '0) || cpu_wr)); // R2

   AST_RD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd != '0) |-> cpu_rd); // R3

   AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (cpu_rdata == '0)); // R7

   AST_SEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_sel != '0) |=> !bus_err); // R7

endmodule

// File: tb/mmio_fabric_tb_top.sv
`timescale 1ns/1ps
module mmio_fabric_tb_top;

   localparam int NS = 8;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [31:0]     cpu_addr, cpu_wdata;
   logic            cpu_wr, cpu_rd;
   logic [31:0]     cpu_rdata;
   logic            bus_err;
   logic [NS-1:0]   dev_sel, dev_wr, dev_rd;
   logic [27:0]     dev_addr;
   logic [31:0]     dev_wdata;
   logic [NS*DW-1:0] dev_rdata;

   always #4 clk = ~clk;

   mmio_fabric dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .bus_err(bus_err),
      .dev_sel(dev_sel), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   // ---------------- device models ----------------
   logic [31:0] ram_mem [16];
   logic [31:0] ram_q;
   logic [31:0] io_reg [NS];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) io_reg[i] <= '0;
      end else begin
         for (int i = 1; i < NS; i++) if (dev_wr[i]) io_reg[i] <= dev_wdata;
      end
   end

   always @(posedge clk) begin
      if (dev_wr[0]) ram_mem[dev_addr[5:2]] <= dev_wdata;
      ram_q <= ram_mem[dev_addr[5:2]];
   end

   function automatic logic [31:0] io_view(input logic [31:0] v, input int idx);
      return v ^ (32'h01010101 * idx);
   endfunction

   always_comb begin
      dev_rdata[31:0] = ram_q;
      for (int i = 1; i < NS; i++) dev_rdata[i*DW +: DW] = io_view(io_reg[i], i);
   end

   // ---------------- reference + scoreboard ----------------
   logic [31:0] ref_ram [16];
   logic [31:0] ref_io  [NS];

   typedef struct {
      int          due;
      logic [31:0] rdata;
      logic        err;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always @(posedge clk) cyc = cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // Driver: one bus cycle, strobe checks, expected item pushed
   task automatic bus(input logic rd, input logic wr, input logic [31:0] addr,
                      input logic [31:0] data, input string req);
      logic [3:0]  reg_f;
      logic [7:0]  e_sel, e_wr, e_rd;
      exp_t        e;
      @(negedge clk);
      cpu_rd = rd; cpu_wr = wr; cpu_addr = addr; cpu_wdata = data;
      #1;
      reg_f = addr[31:28];
      e_sel = '0; e_wr = '0; e_rd = '0;
      if (reg_f < 8 && (rd || wr)) e_sel[reg_f[2:0]] = 1'b1;
      if (reg_f < 8 && wr)         e_wr[reg_f[2:0]]  = 1'b1;
      if (reg_f < 8 && rd)         e_rd[reg_f[2:0]]  = 1'b1;
      check(dev_sel == e_sel, "R1", "dev_sel", 32'(dev_sel), 32'(e_sel));
      check(dev_wr  == e_wr,  "R2", "dev_wr",  32'(dev_wr),  32'(e_wr));
      check(dev_rd  == e_rd,  "R3", "dev_rd",  32'(dev_rd),  32'(e_rd));
      check(dev_addr == addr[27:0] && dev_wdata == data, "R9", "dev_addr",
            32'(dev_addr), 32'(addr[27:0]));
      e.due   = cyc + 1;
      e.err   = (rd || wr) && reg_f >= 8;
      e.rdata = '0;
      e.req   = req;
      if (rd && reg_f == 0)     e.rdata = ref_ram[addr[5:2]];
      else if (rd && reg_f < 8) e.rdata = io_view(ref_io[reg_f], int'(reg_f));
      if (wr && reg_f == 0)     ref_ram[addr[5:2]] = data;
      else if (wr && reg_f < 8) ref_io[reg_f] = data;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 32'h0, 32'h0, "R6");
   endtask

   // Monitor
   always @(negedge clk) begin
      #2;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         check(cpu_rdata == e.rdata, e.req, "cpu_rdata", cpu_rdata, e.rdata);
         check(bus_err == e.err, "R7", "bus_err", 32'(bus_err), 32'(e.err));
      end
   end

   // Watchdog
   initial begin
      #(8 * 200000);
      check(1'b0, "watchdog", "timeout", 32'(cyc), 32'd0);
      summary();
   end

   // Stimulus
   initial begin
      for (int i = 0; i < NS; i++) ref_io[i] = '0;
      for (int i = 0; i < 16; i++) ref_ram[i] = '0;
      rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      // R8: reset values, even with a read pending on an I/O region
      cpu_rd = 1'b1; cpu_addr = 32'h3000_0000;
      @(negedge clk); #1;
      check(cpu_rdata == '0, "R8", "rdata in reset", cpu_rdata, 32'h0);
      check(bus_err == 1'b0, "R8", "err in reset", 32'(bus_err), 32'h0);
      cpu_rd = 1'b0; cpu_addr = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2: writes to every I/O device; following cycles read zero (R6)
      for (int d = 1; d < NS; d++)
         bus(1'b0, 1'b1, {d[3:0], 28'h10}, 32'hA500_0000 + d * 32'h0001_0203, "R6");
      idle(1);
      // R5: read back every I/O device
      for (int d = 1; d < NS; d++)
         bus(1'b1, 1'b0, {d[3:0], 28'h0}, 32'h0, "R5");
      // R4: RAM writes then reads in reverse order, back to back
      for (int w = 0; w < 8; w++)
         bus(1'b0, 1'b1, {4'h0, 22'h0, w[3:0], 2'b00}, 32'hC0DE_0000 + w * 3, "R6");
      for (int w = 7; w >= 0; w--)
         bus(1'b1, 1'b0, {4'h0, 22'h0, w[3:0], 2'b00}, 32'h0, "R4");
      // R4 + R5: alternate RAM and I/O reads
      bus(1'b1, 1'b0, 32'h0000_0008, 32'h0, "R4");
      bus(1'b1, 1'b0, 32'h6000_0000, 32'h0, "R5");
      bus(1'b1, 1'b0, 32'h0000_0014, 32'h0, "R4");
      bus(1'b1, 1'b0, 32'h1000_0004, 32'h0, "R5");
      // R2: write device 3 only; device 4 must keep its value
      bus(1'b0, 1'b1, 32'h3000_0000, 32'h1234_5678, "R6");
      bus(1'b1, 1'b0, 32'h4000_0000, 32'h0, "R2");
      bus(1'b1, 1'b0, 32'h3000_0000, 32'h0, "R2");
      // R2: RAM write immediately followed by read of same word
      bus(1'b0, 1'b1, 32'h0000_003C, 32'hDEAD_BEEF, "R6");
      bus(1'b1, 1'b0, 32'h0000_003C, 32'h0, "R4");
      // R7: unmapped read/write, then a good read right after
      bus(1'b1, 1'b0, 32'h8000_0000, 32'h0, "R7");
      idle(1);
      bus(1'b0, 1'b1, 32'hF000_0010, 32'h5555_AAAA, "R7");
      bus(1'b1, 1'b0, 32'h9000_0020, 32'h0, "R7");
      bus(1'b1, 1'b0, 32'h2000_0000, 32'h0, "R5");
      // R1: no access means no select
      idle(4);
      summary();
   end

endmodule